// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block keeps speculative results in a circular queue so that instructions that finish out of order still update the architectural register file strictly in program order. Dispatch claims the slot at the tail and gets back its index as a tag. Execution units write a result, or a fault flag, into any tagged slot in any order. The head slot retires once it is marked done. A clean result is written into the architectural register file. A faulting head writes nothing, discards every in-flight slot and emits the slot's PC on a one-cycle redirect strobe so that fetch can go to the handler.

A combinational operand lookup serves the scheduler. It looks for the youngest in-flight slot whose destination matches the requested register. If that slot is done, the lookup returns its value. If not, it returns the slot index as a wakeup tag. When no slot matches, the lookup returns the register-file value and marks it ready. The default depth of 8 must be a power of two.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty: allocReady is 1, allocTag is 0, commitValid and redirectValid are 0, and every lookup misses and returns the register-file value 0.
- R2: Each accepted allocation receives the current tail index on allocTag. The next accepted allocation receives that index plus one, modulo DEPTH.
- R3: At most DEPTH slots are in flight. With DEPTH slots occupied, allocReady is 0, and an allocValid presented while allocReady is 0 changes no state.
- R4: Slots retire strictly in allocation order, at most one per cycle, whatever the writeback order. A clean retirement drives commitValid with the slot's destination and value and updates the register file at that clock edge.
- R5: The head retires only once it is done. A writeback to the head in cycle t makes commitValid (or redirectValid) possible no earlier than cycle t+1.
- R6: When several in-flight slots target the same register, the lookup reports the youngest one. It returns that slot's value with lookupReady=1 if the slot is done, and otherwise its index on lookupTag with lookupReady=0.
- R7: A lookup with no matching in-flight slot gives lookupHit=0, lookupReady=1 and the register-file value.
- R8: A done, faulting head raises redirectValid for one cycle with redirectPc equal to that slot's PC, and commitValid stays 0. All slots are discarded, including younger completed ones, none of which ever reaches the register file. In the next cycle the buffer is empty and allocTag is 0.
- R9: In a redirect cycle allocReady is 0, so an allocation in that cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Dispatch requests a slot |
| allocPc | input | PC_W | PC of the dispatched instruction |
| allocDst | input | REG_W | Destination register of the dispatched instruction |
| allocReady | output | 1 | The request is accepted this cycle |
| allocTag | output | IDX_W | Slot index given to the request |
| wbValid | input | 1 | Writeback strobe |
| wbTag | input | IDX_W | Slot being written back |
| wbValue | input | DATA_W | Result value |
| wbFault | input | 1 | The instruction faulted |
| lookupReg | input | REG_W | Register being looked up |
| lookupHit | output | 1 | An in-flight slot produces the register |
| lookupReady | output | 1 | lookupValue is valid |
| lookupValue | output | DATA_W | Operand value |
| lookupTag | output | IDX_W | Producer slot when not ready |
| commitValid | output | 1 | Register-file write this cycle |
| commitDst | output | REG_W | Register-file write address |
| commitValue | output | DATA_W | Register-file write data |
| redirectValid | output | 1 | Fault redirect strobe |
| redirectPc | output | PC_W | PC of the faulting instruction |

## Verification
The hardest case to reach is a faulting slot that sits behind younger slots which have already finished. Both the retirement and the discard of the younger results have to show up at the ports, along with a register file that those results never touched. A directed sequence sets up this case: a divide to f1 that faults, then two younger adds that finish first with the values 11 and 5. Random traffic mixes writeback order, rare faults and reuse of a small set of register numbers, which fills the buffer and stacks several producers of the same register. A reference model in the bench predicts every commit, redirect, acceptance and lookup in every cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic doAlloc;
    logic doCommit;
    logic doFlush;
  } robCtl_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic             headDone,
  input  logic             headFault,
  output robCtl_t          ctl,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             allocReady
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic nonEmpty;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    nonEmpty     = (count != '0);
    ctl.doFlush  = nonEmpty && headDone && headFault;
    ctl.doCommit = nonEmpty && headDone && !headFault;
    allocReady   = (count != FULL_CNT) && !ctl.doFlush;
    ctl.doAlloc  = allocValid && allocReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.doFlush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (ctl.doCommit) head <= bump(head);
      if (ctl.doAlloc)  tail <= bump(tail);
      case ({ctl.doAlloc, ctl.doCommit})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robCtl_t           ctl,
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  tail,
  input  logic [PC_W-1:0]   allocPc,
  input  logic [REG_W-1:0]  allocDst,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbFault,
  input  logic [REG_W-1:0]  lookupReg,
  output logic              headDone,
  output logic              headFault,
  output logic              lookupHit,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue,
  output logic [IDX_W-1:0]  lookupTag,
  output logic [REG_W-1:0]  commitDst,
  output logic [DATA_W-1:0] commitValue,
  output logic [PC_W-1:0]   redirectPc
);
  logic [DEPTH-1:0]  entValid, entDone, entFault;
  logic [PC_W-1:0]   entPc  [DEPTH];
  logic [REG_W-1:0]  entDst [DEPTH];
  logic [DATA_W-1:0] entVal [DEPTH];
  logic [DATA_W-1:0] arf    [NUM_REGS];

  // one storage slot per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    always_ff @(posedge clk) begin
      if (!rstN || ctl.doFlush) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
        entFault[i] <= 1'b0;
      end else begin
        if (ctl.doCommit && head == MY_IDX) entValid[i] <= 1'b0;
        if (ctl.doAlloc && tail == MY_IDX) begin
          entValid[i] <= 1'b1;
          entDone[i]  <= 1'b0;
          entFault[i] <= 1'b0;
          entPc[i]    <= allocPc;
          entDst[i]   <= allocDst;
        end
        if (wbValid && wbTag == MY_IDX && entValid[i]) begin
          entDone[i]  <= 1'b1;
          entFault[i] <= wbFault;
          entVal[i]   <= wbValue;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) arf[r] <= '0;
    end else if (ctl.doCommit) begin
      arf[entDst[head]] <= entVal[head];
    end
  end

  always_comb begin
    headDone    = entValid[head] && entDone[head];
    headFault   = entFault[head];
    commitDst   = entDst[head];
    commitValue = entVal[head];
    redirectPc  = entPc[head];
  end

  // walk oldest to youngest; the last match is the youngest producer
  logic [IDX_W-1:0] selIdx;
  logic             selHit;
  always_comb begin
    logic [IDX_W:0] sum;
    logic [IDX_W-1:0] idx;
    selIdx = '0;
    selHit = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      sum = {1'b0, head} + (IDX_W + 1)'(k);
      if (sum >= (IDX_W + 1)'(DEPTH)) sum = sum - (IDX_W + 1)'(DEPTH);
      idx = sum[IDX_W-1:0];
      if (entValid[idx] && entDst[idx] == lookupReg) begin
        selHit = 1'b1;
        selIdx = idx;
      end
    end
    lookupHit   = selHit;
    lookupTag   = selIdx;
    lookupReady = !selHit || entDone[selIdx];
    lookupValue = selHit ? entVal[selIdx] : arf[lookupReg];
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [PC_W-1:0]   allocPc,
  input  logic [REG_W-1:0]  allocDst,
  output logic              allocReady,
  output logic [IDX_W-1:0]  allocTag,
  input  logic              wbValid,
  input  logic [IDX_W-1:0]  wbTag,
  input  logic [DATA_W-1:0] wbValue,
  input  logic              wbFault,
  input  logic [REG_W-1:0]  lookupReg,
  output logic              lookupHit,
  output logic              lookupReady,
  output logic [DATA_W-1:0] lookupValue,
  output logic [IDX_W-1:0]  lookupTag,
  output logic              commitValid,
  output logic [REG_W-1:0]  commitDst,
  output logic [DATA_W-1:0] commitValue,
  output logic              redirectValid,
  output logic [PC_W-1:0]   redirectPc
);
  robCtl_t          ctl;
  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] occCount;
  logic             headDone, headFault;

  rob_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .headDone(headDone), .headFault(headFault),
    .ctl(ctl), .head(head), .tail(tail), .count(occCount),
    .allocReady(allocReady)
  );

  rob_data #(.DEPTH(DEPTH), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_W(PC_W)) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .head(head), .tail(tail),
    .allocPc(allocPc), .allocDst(allocDst),
    .wbValid(wbValid), .wbTag(wbTag), .wbValue(wbValue), .wbFault(wbFault),
    .lookupReg(lookupReg), .headDone(headDone), .headFault(headFault),
    .lookupHit(lookupHit), .lookupReady(lookupReady),
    .lookupValue(lookupValue), .lookupTag(lookupTag),
    .commitDst(commitDst), .commitValue(commitValue), .redirectPc(redirectPc)
  );

  assign allocTag      = tail;
  assign commitValid   = ctl.doCommit;
  assign redirectValid = ctl.doFlush;
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocTag,
  input logic             commitValid,
  input logic             redirectValid,
  input logic [CNT_W-1:0] occCount,
  input logic             lookupHit,
  input logic             lookupReady
);
  typedef logic [IDX_W-1:0] idx_t;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    occCount <= CNT_W'(DEPTH));

  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occCount == CNT_W'(DEPTH)) |-> !allocReady);

  p_tag_advances_r2: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady) |=> allocTag == idx_t'($past(allocTag) + 1'b1));

  p_commit_needs_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> occCount != '0);

  p_redirect_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(commitValid && redirectValid));

  p_redirect_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (occCount == '0 && allocTag == '0 && !redirectValid));

  p_redirect_blocks_alloc_r9: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !allocReady);

  p_miss_is_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> lookupReady);
endmodule

bind rob_top rob_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .allocTag(allocTag), .commitValid(commitValid), .redirectValid(redirectValid),
  .occCount(occCount), .lookupHit(lookupHit), .lookupReady(lookupReady)
);

// File: tb/rob_top_tb_top.sv
`timescale 1ns/1ps
module rob_top_tb_top;
  localparam int DEPTH = 8;
  localparam int NREG  = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic [31:0] allocPc = '0;
  logic [4:0]  allocDst = '0;
  logic        allocReady;
  logic [2:0]  allocTag;
  logic        wbValid = 1'b0;
  logic [2:0]  wbTag = '0;
  logic [31:0] wbValue = '0;
  logic        wbFault = 1'b0;
  logic [4:0]  lookupReg = '0;
  logic        lookupHit, lookupReady;
  logic [31:0] lookupValue;
  logic [2:0]  lookupTag;
  logic        commitValid;
  logic [4:0]  commitDst;
  logic [31:0] commitValue;
  logic        redirectValid;
  logic [31:0] redirectPc;

  always #4 clk = ~clk;

  rob_top dut_i (.*);

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // reference model state
  bit          mValid[DEPTH], mDone[DEPTH], mFault[DEPTH];
  logic [31:0] mPc[DEPTH], mVal[DEPTH], mArf[NREG];
  logic [4:0]  mDst[DEPTH];
  int          mHead = 0, mTail = 0, mCount = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit modelFlush();
    return mCount > 0 && mDone[mHead] && mFault[mHead];
  endfunction
  function automatic bit modelCommit();
    return mCount > 0 && mDone[mHead] && !mFault[mHead];
  endfunction

  // one cycle: drive at negedge, compare after settling, then advance the model
  task automatic step(input bit aV, input logic [31:0] aPc, input logic [4:0] aDst,
                      input bit wV, input int wT, input logic [31:0] wVal,
                      input bit wF, input logic [4:0] lReg);
    bit eFlush, eCommit, eReady, eHit, eLReady;
    int sel;
    logic [31:0] eLVal;
    allocValid = aV; allocPc = aPc; allocDst = aDst;
    wbValid = wV; wbTag = 3'(wT); wbValue = wVal; wbFault = wF;
    lookupReg = lReg;
    #1;
    eFlush  = modelFlush();
    eCommit = modelCommit();
    eReady  = (mCount != DEPTH) && !eFlush;
    chk(commitValid == eCommit, "R5", "commitValid", commitValid, eCommit);
    if (eCommit)
      chk(commitDst == mDst[mHead] && commitValue == mVal[mHead], "R4", "commit dst/value",
          {27'd0, commitDst, commitValue}, {27'd0, mDst[mHead], mVal[mHead]});
    chk(redirectValid == eFlush, "R8", "redirectValid", redirectValid, eFlush);
    if (eFlush) chk(redirectPc == mPc[mHead], "R8", "redirectPc", redirectPc, mPc[mHead]);
    chk(allocReady == eReady, eFlush ? "R9" : "R3", "allocReady", allocReady, eReady);
    chk(allocTag == 3'(mTail), "R2", "allocTag", allocTag, mTail);
    eHit = 0; sel = 0;
    for (int k = 0; k < mCount; k++) begin
      int ix = (mHead + k) % DEPTH;
      if (mDst[ix] == lReg) begin eHit = 1; sel = ix; end
    end
    eLReady = eHit ? mDone[sel] : 1'b1;
    eLVal   = eHit ? mVal[sel] : mArf[lReg];
    chk(lookupHit == eHit && lookupReady == eLReady, eHit ? "R6" : "R7", "lookup hit/ready",
        {lookupHit, lookupReady}, {eHit, eLReady});
    if (eHit && !eLReady)
      chk(lookupTag == 3'(sel), "R6", "lookupTag", lookupTag, sel);
    else
      chk(lookupValue == eLVal, eHit ? "R6" : "R7", "lookupValue", lookupValue, eLVal);
    // model update for this edge
    if (eFlush) begin
      for (int i = 0; i < DEPTH; i++) begin mValid[i] = 0; mDone[i] = 0; mFault[i] = 0; end
      mHead = 0; mTail = 0; mCount = 0;
    end else begin
      bit wOk = wV && mValid[wT];
      if (eCommit) begin
        mArf[mDst[mHead]] = mVal[mHead];
        mValid[mHead] = 0;
        mHead = (mHead + 1) % DEPTH; mCount--;
      end
      if (aV && eReady) begin
        mValid[mTail] = 1; mDone[mTail] = 0; mFault[mTail] = 0;
        mPc[mTail] = aPc; mDst[mTail] = aDst;
        mTail = (mTail + 1) % DEPTH; mCount++;
      end
      if (wOk) begin mDone[wT] = 1; mFault[wT] = wF; mVal[wT] = wVal; end
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [4:0] lReg);
    step(0, 0, 0, 0, 0, 0, 0, lReg);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) mArf[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin mValid[i] = 0; mDone[i] = 0; mFault[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lookupReg = 5'd3;
    #1;
    // R1 reset state
    chk(allocReady == 1 && allocTag == 0, "R1", "alloc after reset", {allocReady, allocTag}, 4'b1000);
    chk(commitValid == 0 && redirectValid == 0, "R1", "strobes after reset",
        {commitValid, redirectValid}, 0);
    chk(lookupHit == 0 && lookupValue == 0, "R1", "lookup after reset", {lookupHit, lookupValue}, 0);
    @(negedge clk);

    // set r2 = 6, r3 = 5 through the buffer
    step(1, 32'h10, 5'd2, 0, 0, 0, 0, 5'd2);
    step(1, 32'h14, 5'd3, 1, 0, 32'd6, 0, 5'd3);
    step(0, 0, 0, 1, 1, 32'd5, 0, 5'd2);   // commit of r2 in this cycle
    idle(5'd3);
    idle(5'd3);

    // divide to f1 faults after two younger adds complete
    step(1, 32'h100, 5'd1, 0, 0, 0, 0, 5'd1);
    step(1, 32'h104, 5'd3, 0, 0, 0, 0, 5'd3);
    step(1, 32'h108, 5'd4, 0, 0, 0, 0, 5'd3);
    step(0, 0, 0, 1, mTail - 2, 32'd11, 0, 5'd3);  // add -> 11
    step(0, 0, 0, 1, mTail - 1, 32'd5, 0, 5'd3);   // sub -> 5; r3 lookup sees 11
    step(0, 0, 0, 1, mHead, 32'hdead, 1, 5'd4);    // divide faults
    step(1, 32'h200, 5'd7, 0, 0, 0, 0, 5'd3);      // redirect cycle refuses alloc
    chk(lookupValue == 32'd5 && lookupHit == 0, "R8", "r3 after flush", lookupValue, 32'd5);
    chk(allocTag == 0, "R8", "tag after flush", allocTag, 0);
    idle(5'd4);

    // fill past capacity, then write back youngest first
    for (int i = 0; i < DEPTH + 2; i++) step(1, 32'h300 + 4 * i, 5'd6, 0, 0, 0, 0, 5'd6);
    for (int i = DEPTH - 1; i >= 0; i--) step(0, 0, 0, 1, i, 32'h1000 + i, 0, 5'd6);
    repeat (DEPTH + 2) idle(5'd6);

    // constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      bit aV = ($urandom % 10) < 6;
      int slot = $urandom % DEPTH;
      bit wV = mValid[slot] && !mDone[slot] && (($urandom % 4) != 0);
      bit wF = ($urandom % 24) == 0;
      step(aV, $urandom & 32'hffff_fffc, 5'($urandom % 4), wV, slot, $urandom, wF,
           5'($urandom % 5));
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule